// File: doc/BRIEF.md
# Rejected Interrupt Replay Bitmap

This block keeps a record of interrupt sources that the interrupt presenter turned away, so that they can be delivered again later. Every rejection arrives as a one-cycle strobe with a global interrupt number. The block subtracts a programmable base offset to get a local source index and records that index in a two-level bitmap. The lower level is 32 words of 64 bits, which covers 2048 sources. The upper level is a 32-bit summary with one bit per word, set whenever anything in that word is recorded.

When the surrounding logic asks for a resend, the block walks the bitmap once. It uses the summary to jump straight to words that hold records. Within each word it takes every recorded source in ascending order, clears its bit, and presents the source index on a valid/ready output stream as a forced send request. The downstream send logic consumes that stream; the send logic itself is outside this block.

On the output stream a request is offered with `fs_valid`, and it is taken on any rising edge where `fs_valid` and `fs_ready` are both high. While `fs_ready` is low, `fs_valid` stays high and `fs_src` does not change. The block never withdraws an offered source, and it offers at most one source per cycle. Rejects keep being recorded while a sweep is running.

Top module: `rej_replay_top`

## Requirements
- R1: A reject strobe records local source s = `rej_num - rej_base` (32-bit unsigned). It sets bit s mod 64 of word s/64 and summary bit s/64, and a later resend emits `fs_src` = s, an 11-bit value: word index in bits 10:6, bit index in bits 5:0.
- R2: A reject whose computed source is 2048 or more is ignored and is never emitted. Because the subtraction wraps, this includes any number below the base. Source 2047 is still accepted.
- R3: A resend request while the summary is all zero produces no output, and the block stays idle.
- R4: One sweep visits words in ascending index from 0 to 31 and bits in ascending index from 0 to 63, so the sources emitted in a sweep are strictly increasing.
- R5: Each recorded bit is cleared when its source is taken for replay. Repeated rejects of one source before a sweep yield a single emission, and a second resend with no new rejects emits nothing.
- R6: While `fs_valid` is high and `fs_ready` is low, `fs_valid` stays high and `fs_src` holds its value on the next cycle.
- R7: A reject during a sweep is recorded normally. If its word has not yet been passed, or it is a higher bit of the word being emitted, the same sweep emits it. Otherwise it waits for the next resend.
- R8: A resend request that arrives while a sweep is running is ignored.
- R9: Reset clears every bitmap word, the summary and the output stream, so `fs_valid` is low and a resend after reset emits nothing.
- R10: With `fs_ready` held high, consecutive sources within one word are emitted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rej_valid | input | 1 | One-cycle reject strobe |
| rej_num | input | 32 | Global interrupt number being rejected |
| rej_base | input | 32 | Base offset subtracted to form the local source |
| resend_req | input | 1 | Request one replay sweep |
| fs_valid | output | 1 | Forced-send request valid |
| fs_ready | input | 1 | Downstream accepts the forced-send request |
| fs_src | output | 11 | Local source index to send with force |

## Verification
The hardest situation to reach from the ports is a reject that lands while a sweep is in progress, because the outcome depends on where the sweep currently is. The stimulus first records sources in two words, holds `fs_ready` low and issues a resend. It then waits until the first source is offered, which pins the sweep at a known word and bit. With the sweep parked there, it injects rejects into three places: a word already passed, a higher bit of the current word, and a word still ahead. It also pulses a second resend. After releasing `fs_ready`, the bench compares the emitted order against a bitmap model kept in the bench, and a further resend must return only the source from the passed word.

// File: rtl/rej_replay_pkg.sv
package rej_replay_pkg;
  parameter int unsigned RR_WORDS = 32;
  parameter int unsigned RR_BITS  = 64;
  parameter int unsigned RR_NUM_W = 32;

  localparam int unsigned RR_WIDX_W = $clog2(RR_WORDS);
  localparam int unsigned RR_BIDX_W = $clog2(RR_BITS);
  localparam int unsigned RR_SRC_W  = RR_WIDX_W + RR_BIDX_W;

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_PICK = 2'd1,
    SW_EMIT = 2'd2
  } sweep_state_t;
endpackage

// File: rtl/rej_ffs.sv
module rej_ffs #(
  parameter int unsigned W  = 64,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rej_store.sv
module rej_store #(
  parameter int unsigned NW = 32,
  parameter int unsigned NB = 64,
  localparam int unsigned WI = $clog2(NW),
  localparam int unsigned BI = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [WI-1:0] set_w,
  input  logic [BI-1:0] set_b,
  input  logic          clr_en,
  input  logic [WI-1:0] clr_w,
  input  logic [BI-1:0] clr_b,
  input  logic          sclr_en,
  input  logic [WI-1:0] sclr_w,
  input  logic [WI-1:0] rd_w,
  output logic [NB-1:0] rd_word,
  output logic [NW-1:0] summary
);
  logic [NW-1:0][NB-1:0] words_q;
  logic [NW-1:0]         sum_q;

  // A set in the same cycle as a clear of the same bit wins: the later reject stays recorded.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_q <= '0;
      sum_q   <= '0;
    end else begin
      if (clr_en)  words_q[clr_w][clr_b] <= 1'b0;
      if (sclr_en) sum_q[sclr_w]         <= 1'b0;
      if (set_en) begin
        words_q[set_w][set_b] <= 1'b1;
        sum_q[set_w]          <= 1'b1;
      end
    end
  end

  assign rd_word = words_q[rd_w];
  assign summary = sum_q;

  assert_reject_recorded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (words_q[$past(set_w)][$past(set_b)] && sum_q[$past(set_w)]));

  assert_bit_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_w == clr_w && set_b == clr_b))
      |=> !words_q[$past(clr_w)][$past(clr_b)]);
endmodule

// File: rtl/rej_sweep.sv
module rej_sweep
  import rej_replay_pkg::*;
#(
  parameter int unsigned NW = 32,
  parameter int unsigned NB = 64,
  localparam int unsigned WI = $clog2(NW),
  localparam int unsigned BI = $clog2(NB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           resend_req,
  input  logic [NW-1:0]  summary,
  input  logic [NB-1:0]  rd_word,
  output logic [WI-1:0]  rd_w,
  output logic           clr_en,
  output logic [WI-1:0]  clr_w,
  output logic [BI-1:0]  clr_b,
  output logic           sclr_en,
  output logic [WI-1:0]  sclr_w,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [WI+BI-1:0] out_src
);
  sweep_state_t        state_q;
  logic [WI-1:0]       word_q;
  logic [WI:0]         wbase_q;
  logic [BI:0]         bbase_q;
  logic                ov_q;
  logic [WI+BI-1:0]    os_q;

  logic [NW-1:0] sum_mask;
  logic [NB-1:0] bit_mask;
  logic          s_found, b_found;
  logic [WI-1:0] s_idx;
  logic [BI-1:0] b_idx;
  logic          advance;

  // Only words and bits not yet passed by the sweep are candidates.
  for (genvar gi = 0; gi < NW; gi++) begin : g_sum_mask
    assign sum_mask[gi] = summary[gi] & (wbase_q <= (WI+1)'(gi));
  end
  for (genvar gb = 0; gb < NB; gb++) begin : g_bit_mask
    assign bit_mask[gb] = rd_word[gb] & (bbase_q <= (BI+1)'(gb));
  end

  rej_ffs #(.W(NW)) i_word_ffs (.vec(sum_mask), .found(s_found), .idx(s_idx));
  rej_ffs #(.W(NB)) i_bit_ffs  (.vec(bit_mask), .found(b_found), .idx(b_idx));

  assign advance = !ov_q || out_ready;
  assign rd_w    = word_q;
  assign clr_en  = (state_q == SW_EMIT) && advance && b_found;
  assign clr_w   = word_q;
  assign clr_b   = b_idx;
  assign sclr_en = (state_q == SW_PICK) && s_found;
  assign sclr_w  = s_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      word_q  <= '0;
      wbase_q <= '0;
      bbase_q <= '0;
      ov_q    <= 1'b0;
      os_q    <= '0;
    end else begin
      unique case (state_q)
        SW_IDLE: begin
          if (resend_req && (summary != '0)) begin
            wbase_q <= '0;
            state_q <= SW_PICK;
          end
        end
        SW_PICK: begin
          if (s_found) begin
            word_q  <= s_idx;
            bbase_q <= '0;
            state_q <= SW_EMIT;
          end else begin
            state_q <= SW_IDLE;
          end
        end
        SW_EMIT: begin
          if (advance) begin
            if (b_found) begin
              ov_q    <= 1'b1;
              os_q    <= {word_q, b_idx};
              bbase_q <= (BI+1)'(b_idx) + (BI+1)'(1);
            end else begin
              ov_q    <= 1'b0;
              wbase_q <= (WI+1)'(word_q) + (WI+1)'(1);
              state_q <= SW_PICK;
            end
          end
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign out_valid = ov_q;
  assign out_src   = os_q;

  // Checker state: last source handed off in the current sweep.
  logic             have_last_q;
  logic [WI+BI-1:0] last_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_last_q <= 1'b0;
      last_q      <= '0;
    end else if (state_q == SW_IDLE) begin
      have_last_q <= 1'b0;
    end else if (ov_q && out_ready) begin
      have_last_q <= 1'b1;
      last_q      <= os_q;
    end
  end

  assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_src)));

  assert_idle_is_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_IDLE) |-> !out_valid);

  assert_empty_resend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_IDLE && resend_req && summary == '0) |=> (state_q == SW_IDLE));

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && have_last_q) |-> (out_src > last_q));

  assert_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_EMIT && out_valid && out_ready && b_found) |=> out_valid);

  assert_sweep_not_restarted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_EMIT && resend_req) |=> (wbase_q == $past(wbase_q) || $past(!advance) == 1'b0));
endmodule

// File: rtl/rej_replay_top.sv
module rej_replay_top
  import rej_replay_pkg::*;
#(
  parameter int unsigned NW    = RR_WORDS,
  parameter int unsigned NB    = RR_BITS,
  parameter int unsigned NUM_W = RR_NUM_W,
  localparam int unsigned WI    = $clog2(NW),
  localparam int unsigned BI    = $clog2(NB),
  localparam int unsigned SRC_W = WI + BI
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic [NUM_W-1:0] rej_base,
  input  logic             resend_req,
  output logic             fs_valid,
  input  logic             fs_ready,
  output logic [SRC_W-1:0] fs_src
);
  logic [NUM_W-1:0] src_full;
  logic             in_range;
  logic             set_en;
  logic [WI-1:0]    rd_w, clr_w, sclr_w;
  logic [BI-1:0]    clr_b;
  logic             clr_en, sclr_en;
  logic [NB-1:0]    rd_word;
  logic [NW-1:0]    summary;

  // Wrapping subtraction: numbers below the base become huge and fall out of range.
  assign src_full = rej_num - rej_base;
  assign in_range = src_full < NUM_W'(NW * NB);
  assign set_en   = rej_valid && in_range;

  rej_store #(.NW(NW), .NB(NB)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .set_w   (src_full[SRC_W-1:BI]),
    .set_b   (src_full[BI-1:0]),
    .clr_en  (clr_en),
    .clr_w   (clr_w),
    .clr_b   (clr_b),
    .sclr_en (sclr_en),
    .sclr_w  (sclr_w),
    .rd_w    (rd_w),
    .rd_word (rd_word),
    .summary (summary)
  );

  rej_sweep #(.NW(NW), .NB(NB)) i_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .resend_req (resend_req),
    .summary    (summary),
    .rd_word    (rd_word),
    .rd_w       (rd_w),
    .clr_en     (clr_en),
    .clr_w      (clr_w),
    .clr_b      (clr_b),
    .sclr_en    (sclr_en),
    .sclr_w     (sclr_w),
    .out_valid  (fs_valid),
    .out_ready  (fs_ready),
    .out_src    (fs_src)
  );

  assert_below_base_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_valid && rej_num < rej_base) |-> !set_en);
endmodule

// File: tb/test_rej_replay_top.sv
module test_rej_replay_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rej_valid = 1'b0;
  logic [31:0] rej_num = '0;
  logic [31:0] rej_base = '0;
  logic        resend_req = 1'b0;
  logic        fs_valid;
  logic        fs_ready = 1'b1;
  logic [10:0] fs_src;

  always #2 clk = ~clk;

  rej_replay_top i_rej_replay_top (
    .clk(clk), .rst_n(rst_n), .rej_valid(rej_valid), .rej_num(rej_num),
    .rej_base(rej_base), .resend_req(resend_req), .fs_valid(fs_valid),
    .fs_ready(fs_ready), .fs_src(fs_src)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int got[$];
  int stamp[$];
  int stall_err = 0;
  logic prev_stall = 1'b0;
  logic [10:0] prev_src = '0;
  bit model [2048];

  localparam int NV = 11;
  localparam logic [31:0] V_BASE [NV] = '{32'd0, 32'd0, 32'd0, 32'd64, 32'd1000,
    32'd100, 32'd100, 32'd0, 32'd0, 32'd16, 32'd0};
  localparam logic [31:0] V_NUM  [NV] = '{32'd5, 32'd3, 32'd5, 32'd128, 32'd3047,
    32'd2148, 32'd50, 32'd130, 32'd63, 32'd716, 32'd1279};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!fs_valid || fs_src != prev_src)) stall_err++;
      if (fs_valid && fs_ready) begin
        got.push_back(int'(fs_src));
        stamp.push_back(cyc);
      end
      prev_stall = fs_valid && !fs_ready;
      prev_src   = fs_src;
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic reject(input int base, input int num);
    rej_base = 32'(base); rej_num = 32'(num); rej_valid = 1'b1;
    tick();
    rej_valid = 1'b0;
  endtask

  task automatic resend();
    resend_req = 1'b1;
    tick();
    resend_req = 1'b0;
  endtask

  // Runs until the output has been idle for a while; ready follows a pattern.
  task automatic drain(input bit patterned);
    int idle = 0;
    for (int k = 0; k < 4000 && idle < 12; k++) begin
      fs_ready = patterned ? ((k % 3) != 1) : 1'b1;
      tick();
      if (fs_valid) idle = 0; else idle++;
    end
    fs_ready = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int exp_q[$];
    do_reset();
    // R9: reset state
    check(fs_valid == 1'b0, "R9 reset valid", int'(fs_valid), 0);

    // R3: resend with nothing recorded
    got.delete();
    resend();
    repeat (6) tick();
    check(got.size() == 0, "R3 empty resend emits", got.size(), 0);
    check(fs_valid == 1'b0, "R3 idle after empty resend", int'(fs_valid), 0);

    // R1 R2 R4 R5 R6: table of rejects, replay under back-pressure
    for (int v = 0; v < NV; v++) begin
      logic [31:0] s;
      s = V_NUM[v] - V_BASE[v];
      if (s < 32'd2048) model[s] = 1'b1;
      reject(int'(V_BASE[v]), int'(V_NUM[v]));
    end
    got.delete();
    resend();
    drain(1'b1);
    exp_q.delete();
    for (int s = 0; s < 2048; s++) if (model[s]) exp_q.push_back(s);
    check(got.size() == exp_q.size(), "R1 R2 R5 emission count", got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check(got[i] == exp_q[i], "R1 R4 ordered source", got[i], exp_q[i]);
    check(exp_q.size() > 0 && exp_q[exp_q.size()-1] == 2047, "R2 boundary 2047 kept",
          exp_q.size() > 0 ? exp_q[exp_q.size()-1] : -1, 2047);
    foreach (model[s]) model[s] = 1'b0;

    // R5: second resend finds nothing
    got.delete();
    resend();
    drain(1'b0);
    check(got.size() == 0, "R5 second resend empty", got.size(), 0);

    // R7 R8: rejects while the sweep is parked on source 70
    reject(0, 70);
    reject(0, 200);
    fs_ready = 1'b0;
    resend();
    for (int k = 0; k < 50 && !fs_valid; k++) tick();
    check(fs_valid && fs_src == 11'd70, "R7 parked on first source", int'(fs_src), 70);
    reject(0, 10);
    reject(0, 150);
    reject(0, 71);
    resend();
    repeat (4) tick();
    check(fs_valid && fs_src == 11'd70, "R6 held under stall", int'(fs_src), 70);
    got.delete();
    drain(1'b0);
    exp_q = '{70, 71, 150, 200};
    check(got.size() == 4, "R7 R8 mid-sweep count", got.size(), 4);
    for (int i = 0; i < 4 && i < got.size(); i++)
      check(got[i] == exp_q[i], "R7 R8 mid-sweep source", got[i], exp_q[i]);
    got.delete();
    resend();
    drain(1'b0);
    check(got.size() == 1 && got[0] == 10, "R7 passed word deferred",
          got.size() > 0 ? got[0] : -1, 10);

    // R10: one per cycle within a word
    for (int s = 0; s < 8; s++) reject(0, s);
    got.delete(); stamp.delete();
    resend();
    drain(1'b0);
    check(got.size() == 8, "R10 count", got.size(), 8);
    if (stamp.size() == 8)
      check(stamp[7] - stamp[0] == 7, "R10 consecutive cycles", stamp[7] - stamp[0], 7);

    // R9: reset discards recorded sources
    reject(0, 33);
    reject(0, 900);
    do_reset();
    check(fs_valid == 1'b0, "R9 valid after reset", int'(fs_valid), 0);
    got.delete();
    resend();
    drain(1'b0);
    check(got.size() == 0, "R9 nothing after reset", got.size(), 0);

    check(stall_err == 0, "R6 stall stability", stall_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule